// File: doc/BRIEF.md
# Prioritised interrupt level resolver

This block decides, on every clock, whether the processor should be asked to take a level interrupt and which trap type it should use. It merges two sources of pending levels into one vector: the external level request lines and a software interrupt register. Two match bits inside that register, one for the tick timer and one for the system-tick timer, are not levels in their own right. Either of them raises level 14 instead.

The merged vector is compared against the processor's current interrupt level and its global enable. When a level above the current one is pending and interrupts are enabled, the highest such level is chosen. The block then registers a request together with a trap-type index formed from the external-interrupt base code and the level number. A busy flag for a vectored interrupt freezes the outputs, because vectored interrupts outrank all level interrupts. A new request is also held back when the processor is already inside a nested external-interrupt trap whose type is higher than the new one. Trap entry itself and the pipeline are outside this block.

Top module: `irq_level_resolver`

## Requirements
- R1: While reset is asserted, `irq_req` is 0 and `irq_index` is 0.
- R2: The pending vector is the bitwise OR of `ext_lvl[15:0]` and `soft_int[15:0]` with bit 0 of `soft_int` removed, so a software bit k in 1..15 behaves exactly like external line k.
- R3: `soft_int[0]` (tick match) or `soft_int[16]` (system-tick match) sets pending bit 14, giving index 0x04E when no higher level is pending.
- R4: While `vec_busy` is 1 on a clock edge, `irq_req` and `irq_index` keep their values, whatever the other inputs are.
- R5: If the pending vector, read as an unsigned number, is less than 2 shifted left by `cur_lvl`, the next edge clears `irq_req` and `irq_index`. With `cur_lvl` = 15 this always happens.
- R6: Otherwise, with `int_en` = 1, the highest pending bit i above `cur_lvl` gives `irq_index` = 0x040 | i and `irq_req` = 1, one clock after the inputs are applied.
- R7: If `trap_lvl` is nonzero, `trap_type[8:4]` equals 0x04 and `trap_type` is greater than the new index, the outputs are held. A `trap_type` equal to the new index, a different group, or `trap_lvl` = 0 does not block.
- R8: When the chosen index equals the current `irq_index`, both outputs stay unchanged.
- R9: With `vec_busy` = 0 and `int_en` = 0, the next edge clears `irq_req` and `irq_index`.
- R10: Level 0 is never requested. A pending vector holding only bit 0 clears the outputs, and `irq_req` = 1 always comes with an index in 0x041..0x04F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_lvl | input | 16 | External interrupt level lines, bit k = level k |
| soft_int | input | 17 | Software interrupt register; bit 0 tick match, bits 15:1 levels, bit 16 system-tick match |
| cur_lvl | input | 4 | Processor's current interrupt level |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | A vectored interrupt is outstanding |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type | input | 9 | Trap type of the current trap level |
| irq_req | output | 1 | Registered hard-interrupt request |
| irq_index | output | 9 | Registered trap-type index of the request |

## Verification
Any fault in the merge or the priority scan shows at the ports on the very next clock, as a wrong index or a request that should have been withdrawn. A fault in the hold paths (busy, nesting block, unchanged index) appears as an index that moves when it should have stayed. Each vector is therefore checked one clock after it is applied, and the vectors are ordered so that every hold case follows a state with a distinctive nonzero index. Threshold faults are exposed by placing single pending bits just at, just above and well below the current level.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

   // Per-clock decision of the resolver
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_LOAD  = 2'd2
   } irqr_act_e;

   // Default geometry
   localparam int unsigned IRQR_NLVL     = 16;
   localparam int unsigned IRQR_TT_W     = 9;
   localparam int unsigned IRQR_TL_W     = 3;
   localparam int unsigned IRQR_TMR_LVL  = 14;
   localparam int unsigned IRQR_GRP_LSB  = 4;

endpackage

// File: rtl/irqr_merge.sv
module irqr_merge #(
   parameter int unsigned NLVL      = 16,
   parameter int unsigned TMR_LVL   = 14,
   parameter int unsigned TICK_BIT  = 0,
   parameter int unsigned STICK_BIT = NLVL
) (
   input  logic [NLVL-1:0] ext_lvl,
   input  logic [NLVL:0]   soft_int,
   output logic [NLVL-1:0] pend
);

   localparam int unsigned SOFT_W = NLVL + 1;

   logic tmr_hit;

   assign tmr_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

   for (genvar i = 0; i < NLVL; i++) begin : g_bit
      logic soft_lvl;
      if (i == TICK_BIT || i == STICK_BIT) begin : g_timer_slot
         assign soft_lvl = 1'b0;
      end else begin : g_level_slot
         assign soft_lvl = soft_int[i];
      end
      if (i == TMR_LVL) begin : g_fold
         assign pend[i] = ext_lvl[i] | soft_lvl | tmr_hit;
      end else begin : g_plain
         assign pend[i] = ext_lvl[i] | soft_lvl;
      end
   end

   if (TICK_BIT >= SOFT_W || STICK_BIT >= SOFT_W) begin : g_bad_timer_pos
      $error("irqr_merge: timer match bit outside soft register");
   end
   if (TMR_LVL == 0 || TMR_LVL >= NLVL) begin : g_bad_fold
      $error("irqr_merge: timer fold level out of range");
   end

endmodule

// File: rtl/irqr_pick.sv
module irqr_pick #(
   parameter int unsigned NLVL  = 16,
   parameter int unsigned LVL_W = $clog2(NLVL)
) (
   input  logic [NLVL-1:0]  pend,
   input  logic [LVL_W-1:0] cur_lvl,
   output logic             found,
   output logic [LVL_W-1:0] sel
);

   logic [NLVL-1:0] above;

   // keep only levels strictly above the current one
   for (genvar i = 0; i < NLVL; i++) begin : g_mask
      assign above[i] = pend[i] && (LVL_W'(i) > cur_lvl);
   end

   // ascending scan: the last hit is the highest level
   always_comb begin
      found = 1'b0;
      sel   = '0;
      for (int i = 0; i < NLVL; i++) begin
         if (above[i]) begin
            found = 1'b1;
            sel   = LVL_W'(i);
         end
      end
   end

endmodule

// File: rtl/irqr_gate.sv
module irqr_gate
   import irqr_pkg::*;
#(
   parameter int unsigned NLVL    = 16,
   parameter int unsigned LVL_W   = $clog2(NLVL),
   parameter int unsigned TT_W    = 9,
   parameter int unsigned TL_W    = 3,
   parameter int unsigned GRP_LSB = 4,
   parameter logic [TT_W-1:0] BASE = TT_W'(9'h040)
) (
   input  logic [NLVL-1:0]  pend,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic             int_en,
   input  logic             vec_busy,
   input  logic             found,
   input  logic [LVL_W-1:0] sel,
   input  logic [TL_W-1:0]  trap_lvl,
   input  logic [TT_W-1:0]  trap_type,
   input  logic [TT_W-1:0]  cur_idx,
   output irqr_act_e        act,
   output logic [TT_W-1:0]  new_idx
);

   localparam int unsigned THR_W = NLVL + 1;

   logic [THR_W-1:0] thr;
   logic             below;
   logic             in_group;
   logic             nest_block;

   assign thr        = THR_W'(2) << cur_lvl;
   assign below      = {1'b0, pend} < thr;
   assign new_idx    = BASE | TT_W'(sel);
   assign in_group   = trap_type[TT_W-1:GRP_LSB] == BASE[TT_W-1:GRP_LSB];
   assign nest_block = (trap_lvl != '0) && in_group && (trap_type > new_idx);

   always_comb begin
      if (vec_busy)               act = ACT_HOLD;
      else if (below)             act = ACT_CLEAR;
      else if (!int_en)           act = ACT_CLEAR;
      else if (!found)            act = ACT_CLEAR;
      else if (nest_block)        act = ACT_HOLD;
      else if (cur_idx == new_idx) act = ACT_HOLD;
      else                        act = ACT_LOAD;
   end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
   import irqr_pkg::*;
#(
   parameter int unsigned NLVL    = IRQR_NLVL,
   parameter int unsigned TT_W    = IRQR_TT_W,
   parameter int unsigned TL_W    = IRQR_TL_W,
   parameter int unsigned TMR_LVL = IRQR_TMR_LVL,
   parameter logic [TT_W-1:0] BASE = TT_W'(9'h040)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NLVL-1:0]          ext_lvl,
   input  logic [NLVL:0]            soft_int,
   input  logic [$clog2(NLVL)-1:0]  cur_lvl,
   input  logic                     int_en,
   input  logic                     vec_busy,
   input  logic [TL_W-1:0]          trap_lvl,
   input  logic [TT_W-1:0]          trap_type,
   output logic                     irq_req,
   output logic [TT_W-1:0]          irq_index
);

   localparam int unsigned LVL_W   = $clog2(NLVL);
   localparam int unsigned GRP_LSB = IRQR_GRP_LSB;

   if (NLVL < 4 || (NLVL & (NLVL - 1)) != 0) begin : g_bad_nlvl
      $error("irq_level_resolver: NLVL must be a power of two, at least 4");
   end
   if (LVL_W > GRP_LSB || TT_W <= GRP_LSB) begin : g_bad_tt
      $error("irq_level_resolver: trap type too narrow for level field");
   end
   if (BASE[LVL_W-1:0] != '0 || BASE == '0) begin : g_bad_base
      $error("irq_level_resolver: base code must be nonzero with clear level field");
   end

   logic [NLVL-1:0]  pend;
   logic             found;
   logic [LVL_W-1:0] sel;
   irqr_act_e        act;
   logic [TT_W-1:0]  new_idx;

   irqr_merge #(
      .NLVL      (NLVL),
      .TMR_LVL   (TMR_LVL),
      .TICK_BIT  (0),
      .STICK_BIT (NLVL)
   ) u_merge (
      .ext_lvl  (ext_lvl),
      .soft_int (soft_int),
      .pend     (pend)
   );

   irqr_pick #(
      .NLVL  (NLVL),
      .LVL_W (LVL_W)
   ) u_pick (
      .pend    (pend),
      .cur_lvl (cur_lvl),
      .found   (found),
      .sel     (sel)
   );

   irqr_gate #(
      .NLVL    (NLVL),
      .LVL_W   (LVL_W),
      .TT_W    (TT_W),
      .TL_W    (TL_W),
      .GRP_LSB (GRP_LSB),
      .BASE    (BASE)
   ) u_gate (
      .pend      (pend),
      .cur_lvl   (cur_lvl),
      .int_en    (int_en),
      .vec_busy  (vec_busy),
      .found     (found),
      .sel       (sel),
      .trap_lvl  (trap_lvl),
      .trap_type (trap_type),
      .cur_idx   (irq_index),
      .act       (act),
      .new_idx   (new_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req   <= 1'b0;
         irq_index <= '0;
      end else begin
         unique case (act)
            ACT_CLEAR: begin
               irq_req   <= 1'b0;
               irq_index <= '0;
            end
            ACT_LOAD: begin
               irq_req   <= 1'b1;
               irq_index <= new_idx;
            end
            default: ;
         endcase
      end
   end

   // R4: a vectored interrupt freezes both outputs
   p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy |=> $stable(irq_req) && $stable(irq_index));

   // R9: disabled interrupts clear the request
   p_disabled_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_busy && !int_en) |=> (!irq_req && irq_index == '0));

   // R5: nothing above the level means withdrawal
   p_below_withdraw_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vec_busy && !found) |=> (!irq_req && irq_index == '0));

   // R6: the scan only ever selects a level above the current one
   p_pick_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (sel > cur_lvl));

   // R6: a load lands the selected index with the request raised
   p_load_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_LOAD) |=> (irq_req && irq_index == $past(new_idx)));

   // R10: a live request never names level 0 and stays in the group
   p_no_level_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_index[LVL_W-1:0] != '0 &&
                   irq_index[TT_W-1:GRP_LSB] == BASE[TT_W-1:GRP_LSB]));

   // R8: request and index move together
   p_req_tracks_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (irq_index != '0));

endmodule

// File: tb/irq_level_resolver_test.sv
`timescale 1ns/1ps
module irq_level_resolver_test;

   typedef struct {
      logic       req;
      logic [8:0] idx;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_lvl = '0;
   logic [16:0] soft_int = '0;
   logic [3:0]  cur_lvl = '0;
   logic        int_en = 1'b0;
   logic        vec_busy = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  trap_type = '0;
   logic        irq_req;
   logic [8:0]  irq_index;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #2.5 clk = ~clk;

   irq_level_resolver uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_lvl   (ext_lvl),
      .soft_int  (soft_int),
      .cur_lvl   (cur_lvl),
      .int_en    (int_en),
      .vec_busy  (vec_busy),
      .trap_lvl  (trap_lvl),
      .trap_type (trap_type),
      .irq_req   (irq_req),
      .irq_index (irq_index)
   );

   task automatic vec(input logic [15:0] e, input logic [16:0] s,
                      input logic [3:0] l, input bit en, input bit busy,
                      input logic [2:0] tl, input logic [8:0] tt,
                      input bit er, input logic [8:0] ei, input string tag);
      exp_t x;
      @(negedge clk);
      ext_lvl   = e;
      soft_int  = s;
      cur_lvl   = l;
      int_en    = en;
      vec_busy  = busy;
      trap_lvl  = tl;
      trap_type = tt;
      x.req = er;
      x.idx = ei;
      x.tag = tag;
      q.push_back(x);
   endtask

   // monitor: compare one clock after each vector is applied
   always @(posedge clk) begin : mon
      exp_t x;
      #2;
      if (q.size() > 0) begin
         x = q.pop_front();
         n_vec++;
         if (irq_req !== x.req || irq_index !== x.idx) begin
            n_bad++;
            $display("FAIL %s: req=%0b idx=%03h expected req=%0b idx=%03h",
                     x.tag, irq_req, irq_index, x.req, x.idx);
         end
      end
   end

   initial begin
      #20000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int_en = 1'b1;
      ext_lvl = 16'h8000;
      repeat (3) @(negedge clk);
      n_vec++;
      if (irq_req !== 1'b0 || irq_index !== 9'h000) begin
         n_bad++;
         $display("FAIL R1: req=%0b idx=%03h expected req=0 idx=000",
                  irq_req, irq_index);
      end
      ext_lvl = '0;
      rst_n = 1'b1;

      //  ext        soft       lvl en busy tl  tt      req idx
      vec(16'h0000, 17'h00000, 0, 1, 0, 0, 9'h000, 0, 9'h000, "R5 nothing pending");
      vec(16'h0001, 17'h00000, 0, 1, 0, 0, 9'h000, 0, 9'h000, "R10 only level 0");
      vec(16'h0008, 17'h00000, 0, 1, 0, 0, 9'h000, 1, 9'h043, "R6 level 3");
      vec(16'h0208, 17'h00000, 0, 1, 0, 0, 9'h000, 1, 9'h049, "R6 highest of 3,9");
      vec(16'h0208, 17'h00000, 0, 1, 0, 0, 9'h000, 1, 9'h049, "R8 unchanged index");
      vec(16'h0000, 17'h00020, 0, 1, 0, 0, 9'h000, 1, 9'h045, "R2 soft level 5");
      vec(16'h0000, 17'h00001, 0, 1, 0, 0, 9'h000, 1, 9'h04E, "R3 tick match");
      vec(16'h0000, 17'h10000, 0, 1, 0, 0, 9'h000, 1, 9'h04E, "R3 system tick match");
      vec(16'h8000, 17'h10000, 0, 1, 0, 0, 9'h000, 1, 9'h04F, "R3 level 15 beats fold");
      vec(16'h0000, 17'h00000, 0, 1, 1, 0, 9'h000, 1, 9'h04F, "R4 busy holds vs empty");
      vec(16'h0004, 17'h00000, 0, 0, 1, 0, 9'h000, 1, 9'h04F, "R4 busy holds vs disable");
      vec(16'h0080, 17'h00000, 7, 1, 0, 0, 9'h000, 0, 9'h000, "R5 bit at level");
      vec(16'h0100, 17'h00000, 7, 1, 0, 0, 9'h000, 1, 9'h048, "R6 bit just above level");
      vec(16'h0308, 17'h00000, 9, 1, 0, 0, 9'h000, 0, 9'h000, "R5 bits below level 9");
      vec(16'h0000, 17'h00040, 2, 1, 0, 0, 9'h000, 1, 9'h046, "R2 soft level 6");
      vec(16'h8000, 17'h00000, 15, 1, 0, 0, 9'h000, 0, 9'h000, "R5 level 15 masks all");
      vec(16'h0040, 17'h00000, 2, 1, 0, 0, 9'h000, 1, 9'h046, "R6 level 6");
      vec(16'h0400, 17'h00000, 2, 1, 0, 1, 9'h04C, 1, 9'h046, "R7 nested higher blocks");
      vec(16'h0400, 17'h00000, 2, 1, 0, 0, 9'h04C, 1, 9'h04A, "R7 trap level 0 allows");
      vec(16'h0020, 17'h00000, 2, 1, 0, 2, 9'h04A, 1, 9'h04A, "R7 nested 04A blocks 045");
      vec(16'h0020, 17'h00000, 2, 1, 0, 2, 9'h14C, 1, 9'h045, "R7 other group allows");
      vec(16'h1000, 17'h00000, 2, 1, 0, 1, 9'h04C, 1, 9'h04C, "R7 equal type allows");
      vec(16'h1000, 17'h00000, 2, 0, 0, 0, 9'h000, 0, 9'h000, "R9 disabled clears");
      vec(16'h0000, 17'h1FFFF, 0, 1, 0, 0, 9'h000, 1, 9'h04F, "R2 full soft register");
      vec(16'h0001, 17'h00001, 13, 1, 0, 0, 9'h000, 1, 9'h04E, "R3 fold above level 13");
      vec(16'h0001, 17'h00001, 14, 1, 0, 0, 9'h000, 0, 9'h000, "R10 fold at level 14");

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R6: %0d expectations unchecked, expected 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule